// File: doc/BRIEF.md
# Byte-Programmed PWM Generator

A single-channel pulse-width modulator configured through an 8-bit write-only register port. Two 16-bit tick counts set the waveform: the period, which is the length of one cycle, and the duty, which is the number of ticks at the start of each cycle during which the output is high. The host writes each count as two bytes, high byte first.

A counter advances once per pulse of an external tick enable. In the intended system that enable runs at 8 MHz, so one tick is 125 ns. Writing a high byte only stages it. Writing the matching low byte loads the full count into the running generator at once, with no wait for a cycle boundary.

Period and duty commit separately. A host that changes both passes through an intermediate pair of values, and that pair reaches the output. When the duty is greater than or equal to the period, the output is held high for the whole cycle.

Top module: `byte_pwm`

## Requirements
- R1: Register addresses are 0 = period high byte, 1 = period low byte, 2 = duty high byte and 3 = duty low byte. A low-byte write loads {staged high byte, written low byte} into the active count on the same clock edge.
- R2: A high-byte write alone does not change the active period or duty, so the waveform keeps its previous shape until the matching low byte is written.
- R3: The cycle counter changes only on clocks with tick_i high. It counts 0 to period-1 and then returns to 0, so the output pattern repeats every period ticks, whatever the tick rate.
- R4: The polarity is normal. pwm_o is high while the count is below the duty, which gives exactly duty high ticks out of every period ticks when 0 < duty < period.
- R5: When duty >= period and period != 0, pwm_o is high for every tick of the cycle.
- R6: Period and duty commit independently. After only the period is rewritten, the generator runs with the new period and the old duty. If the old duty is at least the new period, this gives a 100% high output.
- R7: If a newly committed period is at or below the current count, the counter returns to 0 on the next tick.
- R8: After reset, period, duty, the staging bytes and the counter are 0 and pwm_o is low. A period of 0 holds pwm_o low for any duty.
- R9: The full 16-bit range works: period 0xFFFF with duty 0xFFFE gives 65534 high ticks out of every 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base enable, one pulse per tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 8 | Write data byte |
| pwm_o | output | 1 | PWM output, active high |

## Verification
The duty ratio is measured by counting high samples over exactly one full period. This count does not depend on where in the cycle the window starts. The ratio is taken for small, multi-byte and maximum counts, and for a divided tick; these patterns tell a wrong byte combination or a wrong wrap point apart from a correct one. Separate scenarios check the following:
- a high-byte write alone leaves the waveform unchanged;
- a duty at or above the period gives a solid high output;
- a period rewritten under a larger old duty forces a 100% high output until the duty is committed;
- a period shrunk below the running count restarts the cycle on the very next tick instead of running on toward the maximum count.

// File: rtl/byte_pwm_pkg.sv
package byte_pwm_pkg;
  localparam int unsigned ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    ADDR_PER_HI  = 2'd0,
    ADDR_PER_LO  = 2'd1,
    ADDR_DUTY_HI = 2'd2,
    ADDR_DUTY_LO = 2'd3
  } reg_addr_e;
  localparam int unsigned NUM_PAIRS = 2;
  localparam int unsigned IDX_PER  = 0;
  localparam int unsigned IDX_DUTY = 1;
endpackage

// File: rtl/pwm_pair_reg.sv
module pwm_pair_reg #(
  parameter int unsigned BYTE_W = 8,
  parameter logic [1:0]  HI_ADDR = 2'd0,
  parameter logic [1:0]  LO_ADDR = 2'd1,
  localparam int unsigned VAL_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [VAL_W-1:0]  value_o
);
  logic [BYTE_W-1:0] stage_q;
  logic [VAL_W-1:0]  value_q;
  logic              hi_we, lo_we;

  assign hi_we = wr_en_i && (wr_addr_i == HI_ADDR);
  assign lo_we = wr_en_i && (wr_addr_i == LO_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      value_q <= '0;
    end else begin
      if (hi_we) stage_q <= wr_data_i;
      if (lo_we) value_q <= {stage_q, wr_data_i};
    end
  end

  assign value_o = value_q;

  // R1
  lo_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_we |=> value_q == {$past(stage_q), $past(wr_data_i)});
  // R2
  hi_no_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_we |=> $stable(value_q));
endmodule

// File: rtl/pwm_cycle_cnt.sv
module pwm_cycle_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  // covers a period shrunk below the running count
  assign wrap = (period_i == '0) || (cnt_q >= period_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  // R3
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && ({1'b0, cnt_q} + 1 < {1'b0, period_i})) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R7
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && period_i != '0 && {1'b0, cnt_q} + 1 >= {1'b0, period_i}) |=> cnt_q == '0);
endmodule

// File: rtl/pwm_out_cmp.sv
module pwm_out_cmp #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             pwm_o
);
  logic run, full;
  assign run  = (period_i != '0);
  assign full = (duty_i >= period_i);
  // count may sit above a fresh period until the next tick; full keeps it high
  assign pwm_o = run && (full || (cnt_i < duty_i));
endmodule

// File: rtl/byte_pwm.sv
module byte_pwm
  import byte_pwm_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic              pwm_o
);
  logic [CNT_W-1:0] pair_val [NUM_PAIRS];
  logic [CNT_W-1:0] cnt;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    pwm_pair_reg #(
      .BYTE_W (BYTE_W),
      .HI_ADDR(2'(2 * g)),
      .LO_ADDR(2'(2 * g + 1))
    ) u_pair (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en_i),
      .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i),
      .value_o  (pair_val[g])
    );
  end

  pwm_cycle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .period_i(pair_val[IDX_PER]),
    .cnt_o   (cnt)
  );

  pwm_out_cmp #(.CNT_W(CNT_W)) u_cmp (
    .period_i(pair_val[IDX_PER]),
    .duty_i  (pair_val[IDX_DUTY]),
    .cnt_i   (cnt),
    .pwm_o   (pwm_o)
  );

  // R8
  zero_period_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_val[IDX_PER] == '0) |-> !pwm_o);
  // R5
  full_duty_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_val[IDX_PER] != '0 && pair_val[IDX_DUTY] >= pair_val[IDX_PER]) |-> pwm_o);
  // R4
  in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt < pair_val[IDX_PER] && pair_val[IDX_DUTY] < pair_val[IDX_PER])
      |-> pwm_o == (cnt < pair_val[IDX_DUTY]));
endmodule

// File: tb/tb_byte_pwm.sv
module tb_byte_pwm;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = 2'd0;
  logic [7:0] wr_data_i = 8'd0;
  logic       pwm_o;

  int n_chk = 0;
  int n_bad = 0;
  int tick_every = 1;
  int tdiv = 0;
  bit done = 1'b0;

  byte_pwm dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .pwm_o(pwm_o)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (tdiv + 1 >= tick_every) tdiv = 0;
    else tdiv = tdiv + 1;
    tick_i <= (tdiv == 0);
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // all tasks start and end at a negedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk); @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic set_period(input int v);
    wr(2'd0, 8'(v >> 8)); wr(2'd1, 8'(v));
  endtask

  task automatic set_duty(input int v);
    wr(2'd2, 8'(v >> 8)); wr(2'd3, 8'(v));
  endtask

  task automatic measure(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      hi += int'(pwm_o);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int hi;
    check("R8 reset low", int'(pwm_o), 0);
    set_duty(5);
    measure(50, hi);
    check("R8 period zero holds low", hi, 0);
  endtask

  task automatic t_basic();
    int hi;
    set_period(10); set_duty(3);
    measure(10, hi); measure(10, hi);
    check("R4 duty 3 of 10", hi, 3);
    set_period(300); set_duty(128);
    measure(300, hi); measure(300, hi);
    check("R1 two-byte period 300 duty 128", hi, 128);
  endtask

  task automatic t_hi_only();
    int hi;
    set_period(10); set_duty(3);
    measure(10, hi);
    wr(2'd0, 8'h05);
    measure(10, hi);
    check("R2 period high byte alone", hi, 3);
    wr(2'd2, 8'h07);
    measure(10, hi);
    check("R2 duty high byte alone", hi, 3);
    wr(2'd1, 8'h14);
    measure(1300, hi); measure(1300, hi);
    check("R1 staged high combined 0x0514 duty 0x0003", hi, 3);
    set_duty(3);
  endtask

  task automatic t_full();
    int hi;
    set_period(8); set_duty(8);
    measure(8, hi);
    check("R5 duty equal period", hi, 8);
    set_duty(20);
    measure(16, hi);
    check("R5 duty above period", hi, 16);
  endtask

  task automatic t_nonatomic();
    int hi;
    set_period(2000); set_duty(1000);
    measure(2000, hi);
    check("R4 duty 1000 of 2000", hi, 1000);
    set_period(800);
    check("R6 immediate high after period commit", int'(pwm_o), 1);
    measure(800, hi);
    check("R6 new period old duty full high", hi, 800);
    set_duty(500);
    measure(800, hi); measure(800, hi);
    check("R6 duty commit 500 of 800", hi, 500);
  endtask

  task automatic t_shrink();
    int g;
    set_period(1000); set_duty(10);
    g = 0;
    while (pwm_o !== 1'b1 && g < 3000) begin @(negedge clk); g++; end
    while (pwm_o !== 1'b0 && g < 3000) begin @(negedge clk); g++; end
    repeat (300) @(negedge clk);
    set_period(100);
    check("R7 low after shrink commit", int'(pwm_o), 0);
    @(negedge clk);
    check("R7 wrap on next tick", int'(pwm_o), 1);
  endtask

  task automatic t_tick();
    int hi;
    set_period(10); set_duty(3);
    tick_every = 4;
    repeat (50) @(negedge clk);
    measure(40, hi);
    check("R3 divided tick 12 of 40 clocks", hi, 12);
    tick_every = 1;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_max();
    int hi;
    set_duty(16'hFFFE); set_period(16'hFFFF);
    measure(65535, hi);
    check("R9 max period", hi, 65534);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 low in reset", int'(pwm_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_hi_only();
    t_full();
    t_nonatomic();
    t_shrink();
    t_tick();
    t_max();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule